// File: doc/BRIEF.md
# Voxel Triangle List Nearest-Hit Tester

This block takes one ray (origin, direction, far limit and the distance at which the ray leaves the current voxel) together with a pointer to the voxel's triangle list. It reads the list one entry at a time from an external list memory. Each entry is a triangle index, and an index of zero ends the list. For every index it reads the three corner positions from three vertex memories that share one address. It then runs an edge/determinant intersection test in signed fixed-point arithmetic. There is no divider. The test works on the scaled quantities u·det, v·det and t·det and normalises the sign of the determinant so that it is always positive.

A running nearest-hit record holds the scaled t, u and v values, the positive determinant and the triangle index. It starts at the ray's far limit. It is replaced only by a candidate that is valid, strictly nearer, and not beyond the voxel exit. When the terminator is read, the block pulses `done`. If any candidate was accepted, it raises `to_shade` and presents the record, so the ray goes on to shading. If none was accepted, the ray goes back to traversal.

The controller is a state machine with these states:
- IDLE waits for `start`.
- LIST_REQ issues a list read.
- LIST_WAIT examines the returned entry. A zero entry moves to REPORT. Any other entry issues the vertex read and moves to VTX_WAIT.
- VTX_WAIT captures the three corners.
- EDGE forms the edge and offset vectors.
- CROSS forms the two cross products.
- DOT forms the four dot products.
- TEST judges the candidate and updates the record, advances the list pointer and returns to LIST_REQ.
- REPORT drives the one-cycle `done` and returns to IDLE.

Each triangle costs seven cycles.

Top module: `tri_list_hit_unit`

## Requirements
- R1: During and right after reset, `busy`, `done`, `lst_rd` and `vtx_rd` are low.
- R2: After `start`, list entries are read at consecutive addresses starting at `voxel_list`, with data one cycle after `lst_rd`. An entry of 0 ends the list. A non-zero entry is the address driven on `vtx_addr` with `vtx_rd` in the next cycle, and each vertex word packs x in bits [CW-1:0], y in [2CW-1:CW] and z in [3CW-1:2CW], all signed.
- R3: A candidate is accepted only if, after sign normalisation, u·det ≥ 0, v·det ≥ 0, u·det + v·det ≤ det and t·det ≥ 0. The edges of the triangle are accepted.
- R4: A candidate with det = 0 is rejected. A candidate with negative det has det, u·det, v·det and t·det all negated, so the reported `hit_det` is always positive.
- R5: A candidate replaces the record only if its t is strictly less than the stored t (compared by cross multiplication). The stored t starts at `ray_tfar`, so t = `ray_tfar` is rejected and, on equal t, the earlier list entry is kept.
- R6: A candidate with t greater than `ray_texit` lies outside the voxel and is rejected. t equal to `ray_texit` is accepted.
- R7: At the end of the list, `done` is high for exactly one cycle. `to_shade` = 1 with the record on `hit_tn`, `hit_un`, `hit_vn`, `hit_det` and `hit_id` if any candidate was accepted; otherwise `to_shade` = 0.
- R8: A `start` while `busy` is high is ignored. The running ray finishes with its own result and only one `done` is produced.
- R9: `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a ray (sampled in IDLE) |
| ray_org | input | 3*CW | Ray origin, packed x/y/z signed |
| ray_dir | input | 3*CW | Ray direction, packed x/y/z signed |
| ray_tfar | input | TW | Far limit of the ray parameter |
| ray_texit | input | TW | Ray parameter at voxel exit |
| voxel_list | input | AW | Address of the first list entry |
| busy | output | 1 | Ray in progress |
| lst_rd | output | 1 | List memory read strobe |
| lst_addr | output | AW | List memory address |
| lst_data | input | IW | List entry (0 terminates) |
| vtx_rd | output | 1 | Vertex memories read strobe |
| vtx_addr | output | IW | Triangle index for vertex memories |
| vtx0_data | input | 3*CW | First corner |
| vtx1_data | input | 3*CW | Second corner |
| vtx2_data | input | 3*CW | Third corner |
| done | output | 1 | One-cycle end-of-list pulse |
| to_shade | output | 1 | 1: hit to shading, 0: miss to traversal |
| hit_tn | output | 3*CW+6 | t·det of nearest hit |
| hit_un | output | 3*CW+6 | u·det of nearest hit |
| hit_vn | output | 3*CW+6 | v·det of nearest hit |
| hit_det | output | 3*CW+6 | Positive determinant of nearest hit |
| hit_id | output | IW | Triangle index of nearest hit |

## Verification
Some properties are checked by assertions on every cycle:
- the memory handshake order (a vertex read always follows a list read, and the two are never issued together);
- the single-cycle `done` inside `busy`;
- the list pointer holding still while a ray runs;
- the record always carrying a positive determinant and a non-negative t.

Other behaviours can only be shown by the bench's scenarios against its own arithmetic model. These are which candidate wins: strictly nearer, ties, the far-limit and voxel-exit boundaries, rejection for a zero determinant, points behind the origin and points outside the edges, and negative-determinant windings. The same holds for a second `start` being ignored mid-ray.

// File: rtl/tlh_pkg.sv
package tlh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LIST_REQ,
        ST_LIST_WAIT,
        ST_VTX_WAIT,
        ST_EDGE,
        ST_CROSS,
        ST_DOT,
        ST_TEST,
        ST_REPORT
    } tlh_state_e;

endpackage

// File: rtl/tlh_ctrl.sv
module tlh_ctrl
    import tlh_pkg::*;
#(
    parameter int AW = 6,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] list_ptr_i,
    input  logic [IW-1:0] lst_data_i,
    output logic          lst_rd_o,
    output logic [AW-1:0] lst_addr_o,
    output logic          vtx_rd_o,
    output logic [IW-1:0] vtx_addr_o,
    output logic [IW-1:0] cur_id_o,
    output logic          load_o,
    output logic          cap_o,
    output logic          edge_en_o,
    output logic          cross_en_o,
    output logic          dot_en_o,
    output logic          test_en_o,
    output logic          busy_o,
    output logic          done_o
);

    tlh_state_e    st_q, st_d;
    logic [AW-1:0] ptr_q;
    logic [IW-1:0] idx_q;
    logic          entry_null;

    assign entry_null = (lst_data_i == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (start_i) st_d = ST_LIST_REQ;
            ST_LIST_REQ:  st_d = ST_LIST_WAIT;
            ST_LIST_WAIT: st_d = entry_null ? ST_REPORT : ST_VTX_WAIT;
            ST_VTX_WAIT:  st_d = ST_EDGE;
            ST_EDGE:      st_d = ST_CROSS;
            ST_CROSS:     st_d = ST_DOT;
            ST_DOT:       st_d = ST_TEST;
            ST_TEST:      st_d = ST_LIST_REQ;
            ST_REPORT:    st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lst_rd_o   = 1'b0;
        vtx_rd_o   = 1'b0;
        load_o     = 1'b0;
        cap_o      = 1'b0;
        edge_en_o  = 1'b0;
        cross_en_o = 1'b0;
        dot_en_o   = 1'b0;
        test_en_o  = 1'b0;
        done_o     = 1'b0;
        busy_o     = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_LIST_REQ:  lst_rd_o   = 1'b1;
            ST_LIST_WAIT: vtx_rd_o   = !entry_null;
            ST_VTX_WAIT:  cap_o      = 1'b1;
            ST_EDGE:      edge_en_o  = 1'b1;
            ST_CROSS:     cross_en_o = 1'b1;
            ST_DOT:       dot_en_o   = 1'b1;
            ST_TEST:      test_en_o  = 1'b1;
            ST_REPORT:    done_o     = 1'b1;
            default:      busy_o     = 1'b0;
        endcase
    end

    assign lst_addr_o = ptr_q;
    assign vtx_addr_o = lst_data_i;
    assign cur_id_o   = idx_q;

    // list pointer and current index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
        end else begin
            if (load_o)
                ptr_q <= list_ptr_i;
            else if (st_q == ST_TEST)
                ptr_q <= ptr_q + AW'(1);
            if (st_q == ST_LIST_WAIT)
                idx_q <= lst_data_i;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_o); // R9
    AST_VTX_AFTER_LIST: assert property (@(posedge clk) disable iff (!rst_n) vtx_rd_o |-> $past(lst_rd_o)); // R2
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lst_rd_o && vtx_rd_o)); // R2
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_TEST) |=> $stable(ptr_q)); // R8

endmodule

// File: rtl/tlh_geom.sv
module tlh_geom #(
    parameter int CW = 8,
    parameter int NW = 3 * CW + 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [3*CW-1:0]      org_i,
    input  logic [3*CW-1:0]      dir_i,
    input  logic                 cap_i,
    input  logic [3*CW-1:0]      c0_i,
    input  logic [3*CW-1:0]      c1_i,
    input  logic [3*CW-1:0]      c2_i,
    input  logic                 edge_en_i,
    input  logic                 cross_en_i,
    input  logic                 dot_en_i,
    output logic signed [NW-1:0] det_o,
    output logic signed [NW-1:0] un_o,
    output logic signed [NW-1:0] vn_o,
    output logic signed [NW-1:0] tn_o
);

    localparam int EW = CW + 1;
    localparam int PW = 2 * CW + 3;

    logic signed [CW-1:0] org_q [3];
    logic signed [CW-1:0] dir_q [3];
    logic signed [CW-1:0] c0_q  [3];
    logic signed [CW-1:0] c1_q  [3];
    logic signed [CW-1:0] c2_q  [3];
    logic signed [EW-1:0] ed1_q [3];
    logic signed [EW-1:0] ed2_q [3];
    logic signed [EW-1:0] off_q [3];
    logic signed [PW-1:0] pv_c  [3];
    logic signed [PW-1:0] qv_c  [3];
    logic signed [PW-1:0] pv_q  [3];
    logic signed [PW-1:0] qv_q  [3];

    // ray and corner capture, edge stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                org_q[i] <= '0;
                dir_q[i] <= '0;
                c0_q[i]  <= '0;
                c1_q[i]  <= '0;
                c2_q[i]  <= '0;
                ed1_q[i] <= '0;
                ed2_q[i] <= '0;
                off_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (load_i) begin
                    org_q[i] <= org_i[i*CW +: CW];
                    dir_q[i] <= dir_i[i*CW +: CW];
                end
                if (cap_i) begin
                    c0_q[i] <= c0_i[i*CW +: CW];
                    c1_q[i] <= c1_i[i*CW +: CW];
                    c2_q[i] <= c2_i[i*CW +: CW];
                end
                if (edge_en_i) begin
                    ed1_q[i] <= EW'(c1_q[i]) - EW'(c0_q[i]);
                    ed2_q[i] <= EW'(c2_q[i]) - EW'(c0_q[i]);
                    off_q[i] <= EW'(org_q[i]) - EW'(c0_q[i]);
                end
            end
        end
    end

    // cross products: pvec = dir x edge2, qvec = offset x edge1
    for (genvar g = 0; g < 3; g++) begin : g_cross
        localparam int J = (g + 1) % 3;
        localparam int K = (g + 2) % 3;
        assign pv_c[g] = PW'(dir_q[J]) * PW'(ed2_q[K]) - PW'(dir_q[K]) * PW'(ed2_q[J]);
        assign qv_c[g] = PW'(off_q[J]) * PW'(ed1_q[K]) - PW'(off_q[K]) * PW'(ed1_q[J]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                pv_q[i] <= '0;
                qv_q[i] <= '0;
            end
        end else if (cross_en_i) begin
            for (int i = 0; i < 3; i++) begin
                pv_q[i] <= pv_c[i];
                qv_q[i] <= qv_c[i];
            end
        end
    end

    // dot products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_o <= '0;
            un_o  <= '0;
            vn_o  <= '0;
            tn_o  <= '0;
        end else if (dot_en_i) begin
            det_o <= NW'(ed1_q[0]) * NW'(pv_q[0]) + NW'(ed1_q[1]) * NW'(pv_q[1])
                   + NW'(ed1_q[2]) * NW'(pv_q[2]);
            un_o  <= NW'(off_q[0]) * NW'(pv_q[0]) + NW'(off_q[1]) * NW'(pv_q[1])
                   + NW'(off_q[2]) * NW'(pv_q[2]);
            vn_o  <= NW'(dir_q[0]) * NW'(qv_q[0]) + NW'(dir_q[1]) * NW'(qv_q[1])
                   + NW'(dir_q[2]) * NW'(qv_q[2]);
            tn_o  <= NW'(ed2_q[0]) * NW'(qv_q[0]) + NW'(ed2_q[1]) * NW'(qv_q[1])
                   + NW'(ed2_q[2]) * NW'(qv_q[2]);
        end
    end

endmodule

// File: rtl/tlh_judge.sv
module tlh_judge #(
    parameter int NW = 30,
    parameter int TW = 12,
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_i,
    input  logic [TW-1:0]        tfar_i,
    input  logic [TW-1:0]        texit_i,
    input  logic                 test_i,
    input  logic signed [NW-1:0] det_i,
    input  logic signed [NW-1:0] un_i,
    input  logic signed [NW-1:0] vn_i,
    input  logic signed [NW-1:0] tn_i,
    input  logic [IW-1:0]        id_i,
    output logic                 found_o,
    output logic signed [NW-1:0] rec_t_o,
    output logic signed [NW-1:0] rec_u_o,
    output logic signed [NW-1:0] rec_v_o,
    output logic signed [NW-1:0] rec_det_o,
    output logic [IW-1:0]        rec_id_o
);

    localparam int MW = 2 * NW;

    logic [TW-1:0]        texit_q;
    logic signed [NW-1:0] tex_s;
    logic                 flip;
    logic signed [NW-1:0] dn, un, vn, tn;
    logic signed [NW:0]   uv_sum, uv_lim;
    logic signed [MW-1:0] near_l, near_r, exit_l, exit_r;
    logic                 valid;

    assign tex_s  = $signed({{(NW-TW){1'b0}}, texit_q});
    assign flip   = det_i[NW-1];
    assign dn     = flip ? -det_i : det_i;
    assign un     = flip ? -un_i  : un_i;
    assign vn     = flip ? -vn_i  : vn_i;
    assign tn     = flip ? -tn_i  : tn_i;
    assign uv_sum = (NW+1)'(un) + (NW+1)'(vn);
    assign uv_lim = (NW+1)'(dn);
    assign near_l = MW'(tn) * MW'(rec_det_o);
    assign near_r = MW'(rec_t_o) * MW'(dn);
    assign exit_l = MW'(tn);
    assign exit_r = MW'(tex_s) * MW'(dn);

    always_comb begin
        valid = 1'b1;
        if (dn == '0)           valid = 1'b0;   // R4
        if (un[NW-1])           valid = 1'b0;   // R3
        if (vn[NW-1])           valid = 1'b0;   // R3
        if (uv_sum > uv_lim)    valid = 1'b0;   // R3
        if (tn[NW-1])           valid = 1'b0;   // R3
        if (!(near_l < near_r)) valid = 1'b0;   // R5
        if (exit_l > exit_r)    valid = 1'b0;   // R6
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            texit_q   <= '0;
            found_o   <= 1'b0;
            rec_t_o   <= '0;
            rec_u_o   <= '0;
            rec_v_o   <= '0;
            rec_det_o <= NW'(1);
            rec_id_o  <= '0;
        end else if (init_i) begin
            texit_q   <= texit_i;
            found_o   <= 1'b0;
            rec_t_o   <= $signed({{(NW-TW){1'b0}}, tfar_i});
            rec_u_o   <= '0;
            rec_v_o   <= '0;
            rec_det_o <= NW'(1);
            rec_id_o  <= '0;
        end else if (test_i && valid) begin
            found_o   <= 1'b1;
            rec_t_o   <= tn;
            rec_u_o   <= un;
            rec_v_o   <= vn;
            rec_det_o <= dn;
            rec_id_o  <= id_i;
        end
    end

    AST_REC_DET_POS: assert property (@(posedge clk) disable iff (!rst_n) rec_det_o > 0); // R4
    AST_REC_T_NONNEG: assert property (@(posedge clk) disable iff (!rst_n) !rec_t_o[NW-1]); // R3

endmodule

// File: rtl/tri_list_hit_unit.sv
module tri_list_hit_unit #(
    parameter int CW = 8,
    parameter int TW = 12,
    parameter int AW = 6,
    parameter int IW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3*CW-1:0]   ray_org,
    input  logic [3*CW-1:0]   ray_dir,
    input  logic [TW-1:0]     ray_tfar,
    input  logic [TW-1:0]     ray_texit,
    input  logic [AW-1:0]     voxel_list,
    output logic              busy,
    output logic              lst_rd,
    output logic [AW-1:0]     lst_addr,
    input  logic [IW-1:0]     lst_data,
    output logic              vtx_rd,
    output logic [IW-1:0]     vtx_addr,
    input  logic [3*CW-1:0]   vtx0_data,
    input  logic [3*CW-1:0]   vtx1_data,
    input  logic [3*CW-1:0]   vtx2_data,
    output logic              done,
    output logic              to_shade,
    output logic [3*CW+5:0]   hit_tn,
    output logic [3*CW+5:0]   hit_un,
    output logic [3*CW+5:0]   hit_vn,
    output logic [3*CW+5:0]   hit_det,
    output logic [IW-1:0]     hit_id
);

    localparam int NW = 3 * CW + 6;

    logic                 load, cap, edge_en, cross_en, dot_en, test_en;
    logic [IW-1:0]        cur_id;
    logic signed [NW-1:0] det_w, un_w, vn_w, tn_w;
    logic signed [NW-1:0] rec_t, rec_u, rec_v, rec_det;

    tlh_ctrl #(.AW(AW), .IW(IW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .list_ptr_i (voxel_list),
        .lst_data_i (lst_data),
        .lst_rd_o   (lst_rd),
        .lst_addr_o (lst_addr),
        .vtx_rd_o   (vtx_rd),
        .vtx_addr_o (vtx_addr),
        .cur_id_o   (cur_id),
        .load_o     (load),
        .cap_o      (cap),
        .edge_en_o  (edge_en),
        .cross_en_o (cross_en),
        .dot_en_o   (dot_en),
        .test_en_o  (test_en),
        .busy_o     (busy),
        .done_o     (done)
    );

    tlh_geom #(.CW(CW), .NW(NW)) geom_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .org_i      (ray_org),
        .dir_i      (ray_dir),
        .cap_i      (cap),
        .c0_i       (vtx0_data),
        .c1_i       (vtx1_data),
        .c2_i       (vtx2_data),
        .edge_en_i  (edge_en),
        .cross_en_i (cross_en),
        .dot_en_i   (dot_en),
        .det_o      (det_w),
        .un_o       (un_w),
        .vn_o       (vn_w),
        .tn_o       (tn_w)
    );

    tlh_judge #(.NW(NW), .TW(TW), .IW(IW)) judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (load),
        .tfar_i    (ray_tfar),
        .texit_i   (ray_texit),
        .test_i    (test_en),
        .det_i     (det_w),
        .un_i      (un_w),
        .vn_i      (vn_w),
        .tn_i      (tn_w),
        .id_i      (cur_id),
        .found_o   (to_shade),
        .rec_t_o   (rec_t),
        .rec_u_o   (rec_u),
        .rec_v_o   (rec_v),
        .rec_det_o (rec_det),
        .rec_id_o  (hit_id)
    );

    assign hit_tn  = rec_t;
    assign hit_un  = rec_u;
    assign hit_vn  = rec_v;
    assign hit_det = rec_det;

endmodule

// File: tb/tri_list_hit_unit_tb_top.sv
module tri_list_hit_unit_tb_top;

    localparam int CW = 8;
    localparam int TW = 12;
    localparam int AW = 6;
    localparam int IW = 5;
    localparam int NW = 3 * CW + 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [3*CW-1:0] ray_org = '0, ray_dir = '0;
    logic [TW-1:0]   ray_tfar = '0, ray_texit = '0;
    logic [AW-1:0]   voxel_list = '0;
    logic            busy, lst_rd, vtx_rd, done, to_shade;
    logic [AW-1:0]   lst_addr;
    logic [IW-1:0]   lst_data = '0, vtx_addr, hit_id;
    logic [3*CW-1:0] vtx0_data = '0, vtx1_data = '0, vtx2_data = '0;
    logic [NW-1:0]   hit_tn, hit_un, hit_vn, hit_det;

    always #2 clk = ~clk;

    tri_list_hit_unit #(.CW(CW), .TW(TW), .AW(AW), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ray_org(ray_org), .ray_dir(ray_dir),
        .ray_tfar(ray_tfar), .ray_texit(ray_texit), .voxel_list(voxel_list), .busy(busy),
        .lst_rd(lst_rd), .lst_addr(lst_addr), .lst_data(lst_data), .vtx_rd(vtx_rd),
        .vtx_addr(vtx_addr), .vtx0_data(vtx0_data), .vtx1_data(vtx1_data),
        .vtx2_data(vtx2_data), .done(done), .to_shade(to_shade), .hit_tn(hit_tn),
        .hit_un(hit_un), .hit_vn(hit_vn), .hit_det(hit_det), .hit_id(hit_id)
    );

    // memories
    logic [IW-1:0] lmem [64];
    int            vtx [32][3][3];

    function automatic logic [3*CW-1:0] pack(input int i, input int k);
        return {CW'(vtx[i][k][2]), CW'(vtx[i][k][1]), CW'(vtx[i][k][0])};
    endfunction

    always @(posedge clk) begin
        if (lst_rd) lst_data <= lmem[lst_addr];
        if (vtx_rd) begin
            vtx0_data <= pack(int'(vtx_addr), 0);
            vtx1_data <= pack(int'(vtx_addr), 1);
            vtx2_data <= pack(int'(vtx_addr), 2);
        end
    end

    typedef struct {
        bit     hit;
        longint tn, un, vn, dn;
        int     id;
        string  tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   ended = 0;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic set_tri(input int id, input int x0, y0, z0, x1, y1, z1, x2, y2, z2);
        vtx[id][0][0] = x0; vtx[id][0][1] = y0; vtx[id][0][2] = z0;
        vtx[id][1][0] = x1; vtx[id][1][1] = y1; vtx[id][1][2] = z1;
        vtx[id][2][0] = x2; vtx[id][2][1] = y2; vtx[id][2][2] = z2;
    endtask

    // reference model built from the requirements
    function automatic exp_t model(input int ptr, input int ox, oy, oz, dx, dy, dz,
                                   input int tf, input int te, input string tag);
        exp_t   e;
        longint o[3], d[3], a[3], b[3], c[3], e1[3], e2[3], tv[3], pv[3], qv[3];
        longint det, u, v, t, rt, rd;
        e.hit = 0; e.tn = 0; e.un = 0; e.vn = 0; e.dn = 1; e.id = 0; e.tag = tag;
        o[0] = ox; o[1] = oy; o[2] = oz; d[0] = dx; d[1] = dy; d[2] = dz;
        rt = tf; rd = 1;
        for (int p = ptr; p < 64; p++) begin
            int id;
            bit ok;
            if (lmem[p] == 0) break;
            id = int'(lmem[p]);
            for (int k = 0; k < 3; k++) begin
                a[k] = vtx[id][0][k]; b[k] = vtx[id][1][k]; c[k] = vtx[id][2][k];
                e1[k] = b[k] - a[k]; e2[k] = c[k] - a[k]; tv[k] = o[k] - a[k];
            end
            for (int k = 0; k < 3; k++) begin
                int j = (k + 1) % 3, m = (k + 2) % 3;
                pv[k] = d[j] * e2[m] - d[m] * e2[j];
                qv[k] = tv[j] * e1[m] - tv[m] * e1[j];
            end
            det = e1[0]*pv[0] + e1[1]*pv[1] + e1[2]*pv[2];
            u   = tv[0]*pv[0] + tv[1]*pv[1] + tv[2]*pv[2];
            v   = d[0]*qv[0]  + d[1]*qv[1]  + d[2]*qv[2];
            t   = e2[0]*qv[0] + e2[1]*qv[1] + e2[2]*qv[2];
            if (det < 0) begin det = -det; u = -u; v = -v; t = -t; end
            ok = (det != 0) && (u >= 0) && (v >= 0) && (u + v <= det) && (t >= 0)
                 && (t * rd < rt * det) && (t <= longint'(te) * det);
            if (ok) begin
                e.hit = 1; e.tn = t; e.un = u; e.vn = v; e.dn = det; e.id = id;
                rt = t; rd = det;
            end
        end
        return e;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 done with no ray outstanding: shade=%0d id=%0d expected no done",
                         to_shade, hit_id);
            end else begin
                bit bad;
                e = exp_q.pop_front();
                bad = (to_shade != e.hit);
                if (e.hit)
                    bad = bad || (int'(hit_id) != e.id) || (longint'($signed(hit_tn)) != e.tn)
                          || (longint'($signed(hit_un)) != e.un) || (longint'($signed(hit_vn)) != e.vn)
                          || (longint'($signed(hit_det)) != e.dn);
                if (bad) begin
                    errors++;
                    $display("FAIL %s: got shade=%0d id=%0d tn=%0d un=%0d vn=%0d det=%0d exp shade=%0d id=%0d tn=%0d un=%0d vn=%0d det=%0d",
                             e.tag, to_shade, hit_id, $signed(hit_tn), $signed(hit_un),
                             $signed(hit_vn), $signed(hit_det), e.hit, e.id, e.tn, e.un, e.vn, e.dn);
                end
            end
        end
    end

    task automatic drive_start(input int ptr, input int ox, oy, oz, dx, dy, dz,
                               input int tf, input int te);
        @(negedge clk);
        ray_org    = {CW'(oz), CW'(oy), CW'(ox)};
        ray_dir    = {CW'(dz), CW'(dy), CW'(dx)};
        ray_tfar   = TW'(tf);
        ray_texit  = TW'(te);
        voxel_list = AW'(ptr);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic run_ray(input int ptr, input int ox, oy, oz, dx, dy, dz,
                           input int tf, input int te, input string tag);
        exp_q.push_back(model(ptr, ox, oy, oz, dx, dy, dz, tf, te, tag));
        drive_start(ptr, ox, oy, oz, dx, dy, dz, tf, te);
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bit(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) lmem[i] = '0;
        for (int i = 0; i < 32; i++)
            for (int k = 0; k < 3; k++)
                for (int c = 0; c < 3; c++) vtx[i][k][c] = 0;
        set_tri(1, 0, 0, 10,  20, 0, 10,  0, 20, 10);  // plane z=10
        set_tri(2, 0, 0, 6,   20, 0, 6,   0, 20, 6);   // nearer
        set_tri(3, 0, 0, 30,  20, 0, 30,  0, 20, 30);  // far
        set_tri(4, 40, 0, 10, 60, 0, 10,  40, 20, 10); // off to the side
        set_tri(5, 0, 0, 0,   0, 20, 0,   0, 0, 20);   // parallel, det 0
        set_tri(6, 0, 0, -4,  20, 0, -4,  0, 20, -4);  // behind
        set_tri(7, 0, 0, 10,  20, 0, 10,  0, 20, 10);  // same as 1
        set_tri(8, 0, 0, 8,   0, 20, 8,   20, 0, 8);   // opposite winding
        lmem[2] = 1;
        lmem[5] = 1; lmem[6] = 2;
        lmem[9] = 2; lmem[10] = 1;
        lmem[13] = 4; lmem[14] = 5; lmem[15] = 6;
        lmem[18] = 3;
        lmem[21] = 1; lmem[22] = 7;
        lmem[25] = 8;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit(busy, 1'b0, "R1 busy in reset");
        check_bit(done | lst_rd | vtx_rd, 1'b0, "R1 strobes in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(busy, 1'b0, "R1 busy after reset");

        run_ray(0,  2, 3, 0, 0, 0, 1, 200, 100, "R2 R7 empty list miss");
        run_ray(2,  2, 3, 0, 0, 0, 1, 200, 100, "R2 R4 single negative-det hit");
        run_ray(5,  2, 3, 0, 0, 0, 1, 200, 100, "R5 later nearer replaces");
        run_ray(9,  2, 3, 0, 0, 0, 1, 200, 100, "R5 later farther kept out");
        run_ray(13, 2, 3, 0, 0, 0, 1, 200, 100, "R3 R4 outside/parallel/behind miss");
        run_ray(18, 2, 3, 0, 0, 0, 1, 200, 20,  "R6 beyond voxel exit miss");
        run_ray(18, 2, 3, 0, 0, 0, 1, 200, 30,  "R6 at voxel exit hit");
        run_ray(2,  2, 3, 0, 0, 0, 1, 10,  100, "R5 t equal far limit miss");
        run_ray(2,  2, 3, 0, 0, 0, 1, 11,  100, "R5 t under far limit hit");
        run_ray(21, 2, 3, 0, 0, 0, 1, 200, 100, "R5 tie keeps first");
        run_ray(25, 2, 3, 0, 0, 0, 1, 200, 100, "R4 positive-det winding");
        run_ray(2,  10, 10, 0, 0, 0, 1, 200, 100, "R3 u+v equals det edge");
        run_ray(2,  0, 5, 0, 0, 0, 1, 200, 100, "R3 u zero edge");
        run_ray(2,  21, 0, 0, 0, 0, 1, 200, 100, "R3 outside u+v miss");
        run_ray(9,  0, 0, 0, 1, 1, 2, 200, 100, "R2 oblique ray two triangles");
        run_ray(9,  2, 3, 0, 0, 0, 2, 200, 4,   "R6 scaled dir exit boundary");

        // R8: second start during a run is ignored
        exp_q.push_back(model(2, 2, 3, 0, 0, 0, 1, 200, 100, "R8 first ray result"));
        drive_start(2, 2, 3, 0, 0, 0, 1, 200, 100);
        repeat (2) @(negedge clk);
        check_bit(busy, 1'b1, "R9 busy during run");
        drive_start(9, 0, 0, 0, 1, 1, 2, 200, 100);
        while (exp_q.size() != 0) @(posedge clk);
        repeat (20) @(negedge clk);
        check_bit(busy, 1'b0, "R8 idle after single result");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, outstanding=%0d expected 0", exp_q.size());
        finish_run();
    end

endmodule